// File: doc/BRIEF.md
# Synthesizer Reference and Programmable Dividers

This block produces the two pulse trains that a frequency synthesizer's phase comparator needs. In the crystal clock domain, a reference divider reduces the crystal clock by one of three ratios: 256, 320 or 512. In the prescaled-VCO clock domain, a programmable divider counts a 15-bit channel word N. The phase detector, the charge pump and the analog prescaler sit outside the block. The block only tells the prescaler which ratio to use.

The block picks the prescaler itself. The choice depends on N and on the step size that the ratio selection implies. The programmable count is then rescaled so that the comparison rate does not move when the prescaler changes over. With the divide-by-4 prescaler, the counter divides by N. With the divide-by-2 prescaler, it divides by 2N. Either way the VCO sees a total ratio of 4N, so the output frequency is 4 × fr × N.

New settings are taken in only at a terminal count, so no comparison period is ever cut short. The settings are expected to change slowly compared with either clock.

Top module: `syn_dividers`

## Requirements
- R1: While `rst_n` is low, `ref_pulse`, `div_pulse` and `presc_quarter` are all 0. A value of 0 on `presc_quarter` selects the divide-by-2 prescaler.
- R2: `ratio_sel` sets the reference ratio. Code 2'b11 selects 256, code 2'b01 selects 512, and codes 2'b10 and 2'b00 select 320. `ref_pulse` recurs every ratio cycles of `xtal_clk`.
- R3: With `ratio_sel` = 2'b11 (finest comparison period, 62.5 kHz step), `presc_quarter` is 1 (divide-by-4) exactly when the effective N is 4096 or more.
- R4: With any other `ratio_sel` code (31.25 kHz or 50 kHz step), `presc_quarter` is 1 exactly when the effective N is 8192 or more.
- R5: `div_pulse` recurs every N cycles of `pre_clk` when `presc_quarter` is 1, and every 2N cycles when it is 0.
- R6: A change of N or `ratio_sel` takes effect only at the next terminal count. The period in progress completes with the old value.
- R7: Each of `ref_pulse` and `div_pulse` is high for exactly one cycle of its own clock per division period.
- R8: An N below 1024 is treated as 1024.
- R9: `presc_quarter` changes only in the cycle in which `div_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtal_clk | input | 1 | Crystal clock feeding the reference divider |
| pre_clk | input | 1 | Prescaled VCO clock feeding the programmable divider |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| n_word | input | 15 | Channel divide word N |
| ratio_sel | input | 2 | Reference ratio code (sets the step size) |
| ref_pulse | output | 1 | One-cycle reference pulse in the `xtal_clk` domain |
| div_pulse | output | 1 | One-cycle divided pulse in the `pre_clk` domain |
| presc_quarter | output | 1 | 1 selects divide-by-4 prescaler, 0 selects divide-by-2 |

## Verification
A wrong count or a wrong latched modulus shows at the ports as a misplaced pulse within one division period. The bench therefore measures the spacing between successive pulses in the cycles of each clock. A wrong prescaler decision shows twice, both in the prescaler select output and in a period that is doubled or halved. Each threshold is probed on both sides. A reload taken at the wrong time appears in the first period after a mid-period change. That period must still carry the old length, and the select output must not move before the pulse that closes it.

// File: rtl/syn_div_pkg.sv
package syn_div_pkg;

  typedef enum logic [1:0] {
    RS_MID_A = 2'b00,
    RS_SLOW  = 2'b01,
    RS_MID_B = 2'b10,
    RS_FAST  = 2'b11
  } ratio_code_e;

  // reference modulus chosen by the ratio code
  function automatic int unsigned ref_modulus(input logic [1:0] sel,
                                              input int unsigned r_fast,
                                              input int unsigned r_mid,
                                              input int unsigned r_slow);
    case (sel)
      RS_FAST: return r_fast;
      RS_SLOW: return r_slow;
      default: return r_mid;
    endcase
  endfunction

  // the finest comparison period uses the lower switchover threshold
  function automatic logic coarse_step(input logic [1:0] sel);
    return sel != RS_FAST;
  endfunction

  function automatic logic pick_quarter(input int unsigned n,
                                        input logic coarse,
                                        input int unsigned th_fine,
                                        input int unsigned th_coarse);
    return n >= (coarse ? th_coarse : th_fine);
  endfunction

  // counter modulus keeping total VCO ratio at 4N
  function automatic int unsigned prog_modulus(input int unsigned n,
                                               input logic quarter);
    return quarter ? n : 2 * n;
  endfunction

endpackage

// File: rtl/syn_ref_div.sv
module syn_ref_div
  import syn_div_pkg::*;
#(
  parameter int unsigned R_FAST = 256,
  parameter int unsigned R_MID  = 320,
  parameter int unsigned R_SLOW = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       pulse
);
  localparam int RW = $clog2(R_SLOW + 1);

  logic [RW-1:0] cnt, mod_q, next_mod;
  logic          armed, pulse_q, reload;

  assign next_mod = RW'(ref_modulus(sel, R_FAST, R_MID, R_SLOW));
  assign reload   = (cnt <= RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      mod_q   <= RW'(R_FAST);
      armed   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= (cnt == RW'(1));
      if (reload) begin
        cnt   <= next_mod;
        mod_q <= next_mod;
        armed <= 1'b1;
      end else begin
        cnt <= cnt - RW'(1);
      end
    end
  end

  assign pulse = pulse_q;

  // R7: one-cycle pulse
  p_ref_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R2: only legal ratios are latched, count stays inside the period
  p_ref_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (mod_q == RW'(R_FAST) || mod_q == RW'(R_MID) || mod_q == RW'(R_SLOW)));

  p_ref_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt != '0 && cnt <= mod_q));

  // R6: latched ratio moves only together with a pulse
  p_ref_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && !pulse_q) |-> $stable(mod_q));

endmodule

// File: rtl/syn_presc_plan.sv
module syn_presc_plan
  import syn_div_pkg::*;
#(
  parameter int unsigned NW        = 15,
  parameter int unsigned N_MIN     = 1024,
  parameter int unsigned TH_FINE   = 4096,
  parameter int unsigned TH_COARSE = 8192
) (
  input  logic [NW-1:0] n_in,
  input  logic [1:0]    sel,
  output logic          quarter,
  output logic [NW:0]   modulus
);
  logic [NW-1:0] n_eff;

  always_comb begin
    n_eff   = (n_in < NW'(N_MIN)) ? NW'(N_MIN) : n_in;
    quarter = pick_quarter(32'(n_eff), coarse_step(sel), TH_FINE, TH_COARSE);
    modulus = (NW + 1)'(prog_modulus(32'(n_eff), quarter));
  end

endmodule

// File: rtl/syn_prog_div.sv
module syn_prog_div #(
  parameter int unsigned MW        = 16,
  parameter int unsigned N_MIN     = 1024,
  parameter int unsigned TH_FINE   = 4096,
  parameter int unsigned TH_COARSE = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] load_mod,
  input  logic          load_quarter,
  output logic          pulse,
  output logic          quarter
);
  logic [MW-1:0] cnt, mod_q;
  logic          armed, pulse_q, quarter_q, reload;

  assign reload = (cnt <= MW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      mod_q     <= '0;
      armed     <= 1'b0;
      pulse_q   <= 1'b0;
      quarter_q <= 1'b0;
    end else begin
      pulse_q <= (cnt == MW'(1));
      if (reload) begin
        cnt       <= load_mod;
        mod_q     <= load_mod;
        quarter_q <= load_quarter;
        armed     <= 1'b1;
      end else begin
        cnt <= cnt - MW'(1);
      end
    end
  end

  assign pulse   = pulse_q;
  assign quarter = quarter_q;

  // R7: one-cycle pulse
  p_div_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R9: prescaler select moves only with a pulse
  p_presc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && !pulse_q) |-> $stable(quarter_q));

  // R6: latched modulus moves only with a pulse
  p_mod_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && !pulse_q) |-> $stable(mod_q));

  // R8: latched modulus never below the minimum word
  p_nmin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> mod_q >= MW'(N_MIN));

  // R3: divide-by-4 is only chosen at or above the lower threshold
  p_quarter_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && quarter_q) |-> mod_q >= MW'(TH_FINE));

  // R4: divide-by-2 never runs with a word above the upper threshold
  p_half_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !quarter_q) |-> mod_q < MW'(2 * TH_COARSE));

  // R5: the half setting always doubles an even count
  p_half_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !quarter_q) |-> !mod_q[0]);

endmodule

// File: rtl/syn_dividers.sv
module syn_dividers
  import syn_div_pkg::*;
#(
  parameter int unsigned NW        = 15,
  parameter int unsigned N_MIN     = 1024,
  parameter int unsigned TH_FINE   = 4096,
  parameter int unsigned TH_COARSE = 8192,
  parameter int unsigned R_FAST    = 256,
  parameter int unsigned R_MID     = 320,
  parameter int unsigned R_SLOW    = 512
) (
  input  logic          xtal_clk,
  input  logic          pre_clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_word,
  input  logic [1:0]    ratio_sel,
  output logic          ref_pulse,
  output logic          div_pulse,
  output logic          presc_quarter
);
  localparam int unsigned MW = NW + 1;

  logic          plan_quarter;
  logic [MW-1:0] plan_mod;

  syn_ref_div #(
    .R_FAST(R_FAST), .R_MID(R_MID), .R_SLOW(R_SLOW)
  ) u_ref (
    .clk  (xtal_clk),
    .rst_n(rst_n),
    .sel  (ratio_sel),
    .pulse(ref_pulse)
  );

  syn_presc_plan #(
    .NW(NW), .N_MIN(N_MIN), .TH_FINE(TH_FINE), .TH_COARSE(TH_COARSE)
  ) u_plan (
    .n_in   (n_word),
    .sel    (ratio_sel),
    .quarter(plan_quarter),
    .modulus(plan_mod)
  );

  syn_prog_div #(
    .MW(MW), .N_MIN(N_MIN), .TH_FINE(TH_FINE), .TH_COARSE(TH_COARSE)
  ) u_prog (
    .clk         (pre_clk),
    .rst_n       (rst_n),
    .load_mod    (plan_mod),
    .load_quarter(plan_quarter),
    .pulse       (div_pulse),
    .quarter     (presc_quarter)
  );

  // R1: outputs idle at the first edge after reset
  p_idle_after_reset_r1: assert property (@(posedge pre_clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!div_pulse && !presc_quarter));

endmodule

// File: tb/test_syn_dividers.sv
module test_syn_dividers;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_PERIOD = 4;
  localparam int WATCHDOG   = 2_000_000;

  logic        xtal_clk = 1'b0;
  logic        pre_clk  = 1'b0;
  logic        rst_n    = 1'b0;
  logic [14:0] n_word   = 15'd2000;
  logic [1:0]  ratio_sel = 2'b11;
  logic        ref_pulse, div_pulse, presc_quarter;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) xtal_clk = ~xtal_clk;
  always #(PRE_PERIOD / 2) pre_clk  = ~pre_clk;

  syn_dividers i_syn_dividers (
    .xtal_clk     (xtal_clk),
    .pre_clk      (pre_clk),
    .rst_n        (rst_n),
    .n_word       (n_word),
    .ratio_sel    (ratio_sel),
    .ref_pulse    (ref_pulse),
    .div_pulse    (div_pulse),
    .presc_quarter(presc_quarter)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [14:0] n;
    logic        quarter;
    int unsigned div_per;
    int unsigned ref_per;
  } vec_t;

  // sel, N, expected select, divided period (pre_clk), reference period (xtal_clk)
  localparam vec_t VECS [8] = '{
    '{2'b11, 15'd1024, 1'b0,  2048, 256},   // R3 low end, half
    '{2'b11, 15'd4095, 1'b0,  8190, 256},   // R3 just below
    '{2'b11, 15'd4096, 1'b1,  4096, 256},   // R3 at threshold
    '{2'b01, 15'd4096, 1'b0,  8192, 512},   // R4 same N, coarse step
    '{2'b10, 15'd8191, 1'b0, 16382, 320},   // R4 just below
    '{2'b00, 15'd8192, 1'b1,  8192, 320},   // R4 at threshold
    '{2'b01, 15'd9000, 1'b1,  9000, 512},   // R5 quarter
    '{2'b11, 15'd100,  1'b0,  2048, 256}    // R8 clamp
  };

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure_div(output int unsigned per);
    int unsigned c;
    do @(negedge pre_clk); while (!div_pulse);
    @(negedge pre_clk);
    check("R7 div pulse width", 32'(div_pulse), 0);
    c = 1;
    while (!div_pulse) begin
      @(negedge pre_clk);
      c++;
    end
    per = c;
  endtask

  task automatic measure_ref(output int unsigned per);
    int unsigned c;
    do @(negedge xtal_clk); while (!ref_pulse);
    @(negedge xtal_clk);
    check("R7 ref pulse width", 32'(ref_pulse), 0);
    c = 1;
    while (!ref_pulse) begin
      @(negedge xtal_clk);
      c++;
    end
    per = c;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #WATCHDOG;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    int unsigned per;
    int unsigned c;

    // R1: reset state
    repeat (5) @(negedge xtal_clk);
    check("R1 ref_pulse in reset", 32'(ref_pulse), 0);
    check("R1 div_pulse in reset", 32'(div_pulse), 0);
    check("R1 presc_quarter in reset", 32'(presc_quarter), 0);
    @(negedge pre_clk);
    rst_n = 1'b1;

    // vector table
    foreach (VECS[i]) begin
      @(negedge pre_clk);
      n_word    = VECS[i].n;
      ratio_sel = VECS[i].sel;
      measure_div(per);      // closes old period, new setting loads at its end
      measure_div(per);
      check($sformatf("R5 divided period vec %0d", i), per, VECS[i].div_per);
      check($sformatf("R3 R4 presc select vec %0d", i), 32'(presc_quarter),
            32'(VECS[i].quarter));
      measure_ref(per);
      measure_ref(per);
      check($sformatf("R2 reference period vec %0d", i), per, VECS[i].ref_per);
    end

    // R6 and R9: N changed mid-period
    @(negedge pre_clk);
    n_word    = 15'd3000;
    ratio_sel = 2'b11;
    measure_div(per);
    measure_div(per);
    check("R5 period N=3000 half", per, 6000);
    do @(negedge pre_clk); while (!div_pulse);
    c = 0;
    repeat (100) begin
      @(negedge pre_clk);
      c++;
    end
    n_word = 15'd5000;
    repeat (100) begin
      @(negedge pre_clk);
      c++;
    end
    check("R9 select held mid-period", 32'(presc_quarter), 0);
    while (!div_pulse) begin
      @(negedge pre_clk);
      c++;
    end
    check("R6 old period completes", c, 6000);
    check("R9 select updates with pulse", 32'(presc_quarter), 1);
    measure_div(per);
    check("R6 new period after reload", per, 5000);

    // R6: reference ratio changed mid-period
    do @(negedge xtal_clk); while (!ref_pulse);
    c = 0;
    repeat (50) begin
      @(negedge xtal_clk);
      c++;
    end
    #1 ratio_sel = 2'b01;
    while (!ref_pulse) begin
      @(negedge xtal_clk);
      c++;
    end
    check("R6 old reference period completes", c, 256);
    measure_ref(per);
    check("R6 new reference period", per, 512);

    finish_run();
  end

endmodule